// File: doc/BRIEF.md
# Sideband Lane-Enable Register Write Gate

This block is the write front end of a small register file whose byte strobes do not come with the data write. A separate control register holds one enable bit per byte lane. Software first writes that control register and then issues the data write. The data write then updates only the byte lanes whose enable bit is set. The enables stay in the control register until the next control write, so a run of writes that use the same lanes needs only one control write.

A 32-bit store sets every lane. A 16-bit store at byte offset `o` sets the two adjacent lanes starting at lane `o`. An 8-bit store sets only lane `o`. Reads of the register file ignore the enables. Reads of the control register return the stored enables in their field and zeros in every other bit. The block also watches the ordering of the two writes. When a control write and a data write arrive in the same cycle, the data write uses the enables that were stored before that cycle, and a one-cycle flag reports the conflict.

Top module: `lanegate_top`

## Requirements
- R1: After reset all lane enables are set. A control read returns 0x00000078. `rd_valid` and `order_flag` are low, and `rd_data` is zero.
- R2: A control write stores `ctl_wdata[6:3]` as the lane enables (bit 3 for byte 0 up to bit 6 for byte 3) and ignores every other bit. A control read returns the stored enables in bits 6:3 and zeros in all other bits.
- R3: A data write to `dat_addr` replaces byte `k` (bits 8k+7:8k) only when lane enable `k` is set. All other bytes of that entry keep their previous value.
- R4: The lane enables stay unchanged through any number of data writes, until the next control write.
- R5: A data write issued while all four lane enables are zero leaves the register file unchanged.
- R6: When `ctl_we` and `dat_we` are both high in one cycle, the data write uses the enables stored before that cycle, and the new enables apply from the next cycle. `order_flag` is high for exactly the cycle after such a collision and low otherwise.
- R7: A read request (`rd_en`, with `rd_ctl`=1 selecting the control register) returns its data on `rd_data` one cycle later, with `rd_valid` high for that one cycle. File reads ignore the lane enables. `rd_data` holds its value while no read is issued.
- R8: A file read and a data write to the same address in one cycle return the entry's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write value; bits 6:3 are the lane enables |
| dat_we | input | 1 | Register file write strobe |
| dat_addr | input | 4 | Register file write address |
| dat_wdata | input | 32 | Register file write data |
| rd_en | input | 1 | Read request |
| rd_ctl | input | 1 | Read source: 1 selects the control register, 0 the file |
| rd_addr | input | 4 | Register file read address |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | High in the cycle `rd_data` carries a new result |
| order_flag | output | 1 | High one cycle after a same-cycle control and data write |

## Verification
The data writes run under full-word enables, under every 16-bit enable pair for offsets 0 to 2, and under every single-byte enable. Each entry is seeded with a distinct byte per lane, so a write to the wrong lane, or a shift that is off by one, shows up as a changed byte. Two checks separate a sticky enable from one that clears itself: several writes follow a single control write, and a write is issued under all-zero enables. Control values with bits set outside 6:3 separate correct field extraction from a store of the whole word. Same-cycle control and data writes tell whether the data write used the old enables or the new ones.

// File: rtl/lanegate_pkg.sv
package lanegate_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SRC_FILE = 1'b0,
    SRC_CTL  = 1'b1
  } rd_src_e;

  function automatic int unsigned word_width(input int unsigned lanes);
    return lanes * BYTE_W;
  endfunction

endpackage

// File: rtl/lanegate_ctl_reg.sv
module lanegate_ctl_reg
  import lanegate_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned CTL_LSB = 3,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  output logic [LANES-1:0]  lane_en,
  output logic [WORD_W-1:0] ctl_view
);

  localparam logic [WORD_W-1:0] FIELD_MASK = WORD_W'({LANES{1'b1}}) << CTL_LSB;

  logic [LANES-1:0] lane_q;
  logic             unused_ctl_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '1;
    end else if (ctl_we) begin
      lane_q <= ctl_wdata[CTL_LSB +: LANES];
    end
  end

  assign lane_en         = lane_q;
  assign ctl_view        = WORD_W'(lane_q) << CTL_LSB;
  assign unused_ctl_bits = ^(ctl_wdata & ~FIELD_MASK);

endmodule

// File: rtl/lanegate_regfile.sv
module lanegate_regfile
  import lanegate_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WORD_W = LANES * BYTE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_en,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we && lane_en[g]) begin
        bank[waddr] <= wdata[g*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q <= '0;
      end else if (re) begin
        rd_q <= bank[raddr];
      end
    end

    assign rdata[g*BYTE_W +: BYTE_W] = rd_q;
  end

endmodule

// File: rtl/lanegate_order_mon.sv
module lanegate_order_mon (
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic dat_we,
  output logic order_flag
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= ctl_we & dat_we;
    end
  end

  assign order_flag = flag_q;

endmodule

// File: rtl/lanegate_top.sv
module lanegate_top
  import lanegate_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CTL_LSB = 3,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              dat_we,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic [WORD_W-1:0] dat_wdata,
  input  logic              rd_en,
  input  logic              rd_ctl,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              order_flag
);

  logic [LANES-1:0]  lane_en;
  logic [WORD_W-1:0] ctl_view;
  logic [WORD_W-1:0] file_rdata;
  logic [WORD_W-1:0] ctl_rd_q;
  rd_src_e           src_q;
  logic              valid_q;

  lanegate_ctl_reg #(
    .LANES  (LANES),
    .CTL_LSB(CTL_LSB)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .lane_en  (lane_en),
    .ctl_view (ctl_view)
  );

  lanegate_regfile #(
    .LANES (LANES),
    .ADDR_W(ADDR_W)
  ) u_file (
    .clk    (clk),
    .rst    (rst),
    .we     (dat_we),
    .waddr  (dat_addr),
    .wdata  (dat_wdata),
    .lane_en(lane_en),
    .re     (rd_en & ~rd_ctl),
    .raddr  (rd_addr),
    .rdata  (file_rdata)
  );

  lanegate_order_mon u_order (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .dat_we    (dat_we),
    .order_flag(order_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rd_q <= '0;
      src_q    <= SRC_FILE;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) begin
        src_q <= rd_ctl ? SRC_CTL : SRC_FILE;
      end
      if (rd_en && rd_ctl) begin
        ctl_rd_q <= ctl_view;
      end
    end
  end

  assign rd_data  = (src_q == SRC_CTL) ? ctl_rd_q : file_rdata;
  assign rd_valid = valid_q;

endmodule

// File: rtl/lanegate_checker.sv
module lanegate_checker #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned CTL_LSB = 3,
  localparam int unsigned WORD_W = LANES * 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [LANES-1:0]  ctl_field,
  input logic              dat_we,
  input logic              rd_en,
  input logic              rd_ctl,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              order_flag,
  input logic [LANES-1:0]  lane_en
);

  assert_ctl_store_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (lane_en == $past(ctl_field)));

  assert_ctl_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_ctl) |=> (rd_data == (WORD_W'($past(lane_en)) << CTL_LSB)));

  assert_enables_persist_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(lane_en));

  assert_collision_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && dat_we) |=> order_flag);

  assert_no_spurious_flag_R6: assert property (@(posedge clk) disable iff (rst)
    !(ctl_we && dat_we) |=> !order_flag);

  assert_read_valid_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

endmodule

bind lanegate_top lanegate_checker #(
  .LANES  (LANES),
  .CTL_LSB(CTL_LSB)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_we    (ctl_we),
  .ctl_field (ctl_wdata[CTL_LSB +: LANES]),
  .dat_we    (dat_we),
  .rd_en     (rd_en),
  .rd_ctl    (rd_ctl),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .order_flag(order_flag),
  .lane_en   (lane_en)
);

// File: tb/lanegate_top_test.sv
module lanegate_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        dat_we = 1'b0;
  logic [3:0]  dat_addr = '0;
  logic [31:0] dat_wdata = '0;
  logic        rd_en = 1'b0;
  logic        rd_ctl = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        order_flag;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  logic [31:0] m_mem [16];
  logic [3:0]  m_lanes;
  logic [31:0] m_data;
  logic        m_valid;
  logic        m_order;

  always #4 clk = ~clk;

  lanegate_top uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_addr(dat_addr), .dat_wdata(dat_wdata),
    .rd_en(rd_en), .rd_ctl(rd_ctl), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .order_flag(order_flag)
  );

  function automatic logic [31:0] merge(input logic [31:0] old_w,
                                        input logic [31:0] new_w,
                                        input logic [3:0] en);
    logic [31:0] r = old_w;
    for (int b = 0; b < 4; b++) if (en[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  // Behavioural reference: read sees old contents and old enables.
  always @(posedge clk) begin
    if (rst) begin
      m_lanes = 4'hF; m_data = '0; m_valid = 1'b0; m_order = 1'b0;
    end else begin
      m_valid = rd_en;
      if (rd_en) m_data = rd_ctl ? {25'd0, m_lanes, 3'd0} : m_mem[rd_addr];
      if (dat_we) m_mem[dat_addr] = merge(m_mem[dat_addr], dat_wdata, m_lanes);
      m_order = ctl_we && dat_we;
      if (ctl_we) m_lanes = ctl_wdata[6:3];
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (!rst) begin
      check(cur_req, "rd_valid", {31'd0, rd_valid}, {31'd0, m_valid});
      check(cur_req, "order_flag", {31'd0, order_flag}, {31'd0, m_order});
      check(cur_req, "rd_data", rd_data, m_data);
    end
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_we = 1'b1; ctl_wdata = v; tick(); ctl_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [3:0] a, input logic [31:0] v);
    dat_we = 1'b1; dat_addr = a; dat_wdata = v; tick(); dat_we = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic sel_ctl,
                           input logic [3:0] a, input logic [31:0] exp);
    rd_en = 1'b1; rd_ctl = sel_ctl; rd_addr = a; tick(); rd_en = 1'b0;
    check(req, "read value", rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] base;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    cur_req = "R1";
    tick();
    check("R1", "rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    check("R1", "order_flag after reset", {31'd0, order_flag}, 32'd0);
    check("R1", "rd_data after reset", rd_data, 32'd0);
    rd_expect("R1", 1'b1, 4'd0, 32'h0000_0078);

    // R3: seed every entry with full-lane writes
    cur_req = "R3";
    for (int a = 0; a < 16; a++) wr_dat(a[3:0], {a[7:0], 8'hB0 | a[7:0], 8'hC0 | a[7:0], 8'hD0 | a[7:0]});
    for (int a = 0; a < 16; a++)
      rd_expect("R3", 1'b0, a[3:0], {a[7:0], 8'hB0 | a[7:0], 8'hC0 | a[7:0], 8'hD0 | a[7:0]});

    // R2: only bits 6:3 kept
    cur_req = "R2";
    wr_ctl(32'hFFFF_FFFF);
    rd_expect("R2", 1'b1, 4'd0, 32'h0000_0078);
    wr_ctl(32'hFFFF_FF97);
    rd_expect("R2", 1'b1, 4'd0, 32'h0000_0010);

    // R3: single-byte lanes
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      base = m_mem[4'd1];
      wr_ctl(32'h8 << s);
      wr_dat(4'd1, 32'h5A5A_5A5A ^ (32'h11 << (8 * s)));
      rd_expect("R3", 1'b0, 4'd1, merge(base, 32'h5A5A_5A5A ^ (32'h11 << (8 * s)), 4'h1 << s));
    end
    // R3: halfword lane pairs
    for (int s = 0; s < 3; s++) begin
      base = m_mem[4'd2];
      wr_ctl(32'h18 << s);
      wr_dat(4'd2, 32'h1234_5678 + s);
      rd_expect("R3", 1'b0, 4'd2, merge(base, 32'h1234_5678 + s, 4'h3 << s));
    end

    // R4: enables persist over several writes
    cur_req = "R4";
    wr_ctl(32'h0000_0020);
    for (int k = 0; k < 3; k++) begin
      base = m_mem[4'd3 + k[3:0]];
      wr_dat(4'd3 + k[3:0], 32'hEEEE_EEEE);
      rd_expect("R4", 1'b0, 4'd3 + k[3:0], merge(base, 32'hEEEE_EEEE, 4'h4));
    end
    rd_expect("R4", 1'b1, 4'd0, 32'h0000_0020);

    // R5: all enables zero
    cur_req = "R5";
    wr_ctl(32'h0000_0087);
    base = m_mem[4'd7];
    wr_dat(4'd7, 32'hDEAD_BEEF);
    rd_expect("R5", 1'b0, 4'd7, base);
    rd_expect("R5", 1'b1, 4'd0, 32'h0000_0000);

    // R6: control and data write together
    cur_req = "R6";
    wr_ctl(32'h0000_0008);
    base = m_mem[4'd8];
    ctl_we = 1'b1; ctl_wdata = 32'h0000_0040;
    dat_we = 1'b1; dat_addr = 4'd8; dat_wdata = 32'h9999_9999;
    tick();
    ctl_we = 1'b0; dat_we = 1'b0;
    check("R6", "flag after collision", {31'd0, order_flag}, 32'd1);
    tick();
    check("R6", "flag one cycle only", {31'd0, order_flag}, 32'd0);
    rd_expect("R6", 1'b0, 4'd8, merge(base, 32'h9999_9999, 4'h1));
    rd_expect("R6", 1'b1, 4'd0, 32'h0000_0040);

    // R7: hold, back-to-back reads
    cur_req = "R7";
    rd_expect("R7", 1'b0, 4'd9, m_mem[4'd9]);
    held = rd_data;
    tick(); tick();
    check("R7", "rd_data hold", rd_data, held);
    check("R7", "rd_valid idle", {31'd0, rd_valid}, 32'd0);
    rd_expect("R7", 1'b0, 4'd10, m_mem[4'd10]);
    rd_expect("R7", 1'b1, 4'd0, 32'h0000_0040);
    rd_expect("R7", 1'b0, 4'd11, m_mem[4'd11]);

    // R8: same-address read and write
    cur_req = "R8";
    wr_ctl(32'h0000_0078);
    base = m_mem[4'd12];
    dat_we = 1'b1; dat_addr = 4'd12; dat_wdata = 32'h0BAD_F00D;
    rd_en = 1'b1; rd_ctl = 1'b0; rd_addr = 4'd12;
    tick();
    dat_we = 1'b0; rd_en = 1'b0;
    check("R8", "read-first value", rd_data, base);
    rd_expect("R8", 1'b0, 4'd12, 32'h0BAD_F00D);

    tick();
    finish_run();
  end

endmodule